// File: doc/BRIEF.md
# 8-bit ALU with selective status flags

This block is the arithmetic and logic unit of a small load/store processor. It is purely combinational. Each evaluation takes two 8-bit operands, a 4-bit operation code and the processor's current flag byte. It returns an 8-bit result, an updated flag byte and a write-back enable.

The flag byte carries five meaningful bits: carry C in bit 7, zero Z in bit 6, sign S in bit 5, overflow V in bit 4 and halt H in bit 3. Bits 2..0 are unused. Each operation rewrites only the flags it owns and copies every other bit of the byte from the input.

Compare and bit test yield flags like subtract and AND respectively. They drop write-back so that the destination register keeps its value. Moves and loads send the second operand through unchanged, and that value still sets Z and S.

The house style centres on state machines, but the block holds no state. Its single decision point is the operation decode, a `unique case` on the operation code in the top module. That decode plays the role of the output process. There are no states and no transitions.

Operation codes are 0 PASS, 1 ADD, 2 SUB, 3 CMP, 4 AND, 5 OR, 6 XOR, 7 TST, 8 ROR, 9 SHL and 10 SHR. Codes 11 to 15 are undefined.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 1) yields a+b modulo 256. C (bit 7) is the carry out. V (bit 4) is 1 when both operands have the same bit 7 and the result's bit 7 differs from it.
- R2: SUB (code 2) and CMP (code 3) yield a+(~b)+1 modulo 256. C is the carry out of that sum, so C=1 exactly when a>=b unsigned. V is 1 when the operands differ in bit 7 and the result's bit 7 differs from a's bit 7.
- R3: wr_en is 0 for CMP (code 3) and TST (code 7). It is 1 for codes 0 to 10 other than those two.
- R4: For codes 0 to 10, Z (bit 6) is 1 exactly when the result is zero, and S (bit 5) equals result bit 7.
- R5: AND, OR, XOR and TST (codes 4, 5, 6, 7) yield the bitwise function, with TST using AND. They leave C and V at their input values.
- R6: ROR (code 8) rotates a right by b[2:0] positions and ignores b[7:3]. It updates Z and S only.
- R7: SHL (code 9) sets C to a[7] and yields a shifted left by one with a 0 in bit 0. V is result[7] XOR a[7].
- R8: SHR (code 10) sets C to a[0] and yields a shifted right by one with a 0 in bit 7. V is result[7] XOR a[7].
- R9: flags_out[3:0], the H bit and the three unused bits, always equal flags_in[3:0].
- R10: PASS (code 0) yields b as the result. It updates Z and S only and leaves C and V at their input values.
- R11: Undefined codes 11 to 15 yield a as the result, return flags_out equal to flags_in and drive wr_en to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | 8 | First operand (destination register value) |
| opd_b | input | 8 | Second operand (immediate, source register or loaded data) |
| op_sel | input | 4 | Operation code, 0 to 10 defined |
| flags_in | input | 8 | Current flag byte {C,Z,S,V,H,3 unused} |
| result | output | 8 | Operation result |
| flags_out | output | 8 | Updated flag byte |
| wr_en | output | 1 | Result should be written back |

## Verification
Every output settles in the same cycle as its stimulus, with no register between the inputs and the outputs. The driver applies a vector on the falling clock edge and queues the expected item. The monitor pops and compares the item on the following rising edge, half a period later. Each comparison therefore sees exactly the vector that was driven. Directed vectors cover the carry, borrow, overflow, zero-result and rotate-amount corners, and a random sweep covers every code, including the undefined ones.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    typedef enum logic [3:0] {
        OP_PASS = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_CMP  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_TST  = 4'd7,
        OP_ROR  = 4'd8,
        OP_SHL  = 4'd9,
        OP_SHR  = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2
    } bw_sel_e;

    typedef enum logic [1:0] {
        SH_ROR = 2'd0,
        SH_SHL = 2'd1,
        SH_SHR = 2'd2
    } sh_sel_e;

    localparam int FLAG_W = 8;
    localparam int FLG_C  = 7;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 5;
    localparam int FLG_V  = 4;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        sum   = wide[WIDTH-1:0];
        cout  = wide[WIDTH];
        // same-sign inputs to the adder producing a different sign
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0]       a,
    input  logic [WIDTH-1:0]       b,
    input  alu8_pkg::bw_sel_e      sel,
    output logic [WIDTH-1:0]       y
);
    import alu8_pkg::*;

    always_comb begin
        unique case (sel)
            BW_OR:   y = a | b;
            BW_XOR:  y = a ^ b;
            default: y = a & b;
        endcase
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int WIDTH = 8,
    localparam int STAGES = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [STAGES-1:0] amt,
    input  alu8_pkg::sh_sel_e sel,
    output logic [WIDTH-1:0]  y,
    output logic              cout
);
    import alu8_pkg::*;

    logic [WIDTH-1:0] stg [0:STAGES];

    assign stg[0] = a;

    // logarithmic rotate: stage k rotates by 2**k when amt[k] is set
    for (genvar k = 0; k < STAGES; k++) begin : g_rot
        localparam int D = 1 << k;
        assign stg[k+1] = amt[k] ? {stg[k][D-1:0], stg[k][WIDTH-1:D]} : stg[k];
    end

    always_comb begin
        unique case (sel)
            SH_SHL: begin
                y    = {a[WIDTH-2:0], 1'b0};
                cout = a[WIDTH-1];
            end
            SH_SHR: begin
                y    = {1'b0, a[WIDTH-1:1]};
                cout = a[0];
            end
            default: begin
                y    = stg[STAGES];
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int WIDTH = 8,
    localparam int OPW = 4
) (
    input  logic [WIDTH-1:0] opd_a,
    input  logic [WIDTH-1:0] opd_b,
    input  logic [OPW-1:0]   op_sel,
    input  logic [7:0]       flags_in,
    output logic [WIDTH-1:0] result,
    output logic [7:0]       flags_out,
    output logic             wr_en
);
    import alu8_pkg::*;

    localparam int STAGES = $clog2(WIDTH);

    alu_op_e          op;
    logic             is_sub;
    logic [WIDTH-1:0] as_sum;
    logic             as_c;
    logic             as_v;
    bw_sel_e          bw_sel;
    logic [WIDTH-1:0] bw_y;
    sh_sel_e          sh_sel;
    logic [WIDTH-1:0] sh_y;
    logic             sh_c;

    logic             upd_zs;
    logic             upd_cv;
    logic             c_new;
    logic             v_new;

    assign op     = alu_op_e'(op_sel);
    assign is_sub = (op == OP_SUB) || (op == OP_CMP);

    always_comb begin
        unique case (op)
            OP_OR:   bw_sel = BW_OR;
            OP_XOR:  bw_sel = BW_XOR;
            default: bw_sel = BW_AND;
        endcase
        unique case (op)
            OP_SHL:  sh_sel = SH_SHL;
            OP_SHR:  sh_sel = SH_SHR;
            default: sh_sel = SH_ROR;
        endcase
    end

    alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a    (opd_a),
        .b    (opd_b),
        .sub  (is_sub),
        .sum  (as_sum),
        .cout (as_c),
        .ovf  (as_v)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a   (opd_a),
        .b   (opd_b),
        .sel (bw_sel),
        .y   (bw_y)
    );

    alu8_shift #(.WIDTH(WIDTH)) u_shift (
        .a    (opd_a),
        .amt  (opd_b[STAGES-1:0]),
        .sel  (sh_sel),
        .y    (sh_y),
        .cout (sh_c)
    );

    // operation decode: selects result, write-back and which flags change
    always_comb begin
        result = opd_a;
        wr_en  = 1'b0;
        upd_zs = 1'b0;
        upd_cv = 1'b0;
        c_new  = flags_in[FLG_C];
        v_new  = flags_in[FLG_V];
        unique case (op)
            OP_PASS: begin
                result = opd_b;
                wr_en  = 1'b1;
                upd_zs = 1'b1;
            end
            OP_ADD, OP_SUB, OP_CMP: begin
                result = as_sum;
                wr_en  = (op != OP_CMP);
                upd_zs = 1'b1;
                upd_cv = 1'b1;
                c_new  = as_c;
                v_new  = as_v;
            end
            OP_AND, OP_OR, OP_XOR, OP_TST: begin
                result = bw_y;
                wr_en  = (op != OP_TST);
                upd_zs = 1'b1;
            end
            OP_ROR: begin
                result = sh_y;
                wr_en  = 1'b1;
                upd_zs = 1'b1;
            end
            OP_SHL, OP_SHR: begin
                result = sh_y;
                wr_en  = 1'b1;
                upd_zs = 1'b1;
                upd_cv = 1'b1;
                c_new  = sh_c;
                v_new  = sh_y[WIDTH-1] ^ opd_a[WIDTH-1];
            end
            default: begin
                result = opd_a;
            end
        endcase
    end

    // flag merge: start from the incoming byte, overwrite owned bits
    always_comb begin
        flags_out = flags_in;
        if (upd_zs) begin
            flags_out[FLG_Z] = ~|result;
            flags_out[FLG_S] = result[WIDTH-1];
        end
        if (upd_cv) begin
            flags_out[FLG_C] = c_new;
            flags_out[FLG_V] = v_new;
        end
    end
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opd_a,
    input logic [WIDTH-1:0] opd_b,
    input logic [3:0]       op_sel,
    input logic [7:0]       flags_in,
    input logic [WIDTH-1:0] result,
    input logic [7:0]       flags_out,
    input logic             wr_en
);
    always_comb begin
        if (!$isunknown({opd_a, opd_b, op_sel, flags_in})) begin
            p_upper_hold_r9: assert (flags_out[3:0] == flags_in[3:0])
                else $error("R9 low flag bits altered");
            p_no_wb_r3: assert (!((op_sel == 4'd3 || op_sel == 4'd7) && wr_en))
                else $error("R3 compare/test wrote back");
            if (op_sel <= 4'd10) begin
                p_zero_flag_r4: assert (flags_out[6] == (result == '0))
                    else $error("R4 Z flag wrong");
                p_sign_flag_r4: assert (flags_out[5] == result[WIDTH-1])
                    else $error("R4 S flag wrong");
            end
            if (op_sel >= 4'd4 && op_sel <= 4'd7) begin
                p_keep_cv_r5: assert (flags_out[7] == flags_in[7] && flags_out[4] == flags_in[4])
                    else $error("R5 C/V changed by logic op");
            end
            if (op_sel == 4'd2) begin
                p_no_borrow_r2: assert (flags_out[7] == (opd_a >= opd_b))
                    else $error("R2 borrow flag wrong");
            end
            if (op_sel == 4'd9) begin
                p_shl_carry_r7: assert (flags_out[7] == opd_a[WIDTH-1])
                    else $error("R7 carry wrong");
            end
            if (op_sel == 4'd10) begin
                p_shr_carry_r8: assert (flags_out[7] == opd_a[0])
                    else $error("R8 carry wrong");
            end
            if (op_sel >= 4'd11) begin
                p_undef_r11: assert (!wr_en && flags_out == flags_in && result == opd_a)
                    else $error("R11 undefined op not inert");
            end
        end
    end
endmodule

bind alu8_core alu8_chk #(.WIDTH(WIDTH)) u_chk (
    .opd_a     (opd_a),
    .opd_b     (opd_b),
    .op_sel    (op_sel),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .wr_en     (wr_en)
);

// File: tb/test_alu8_core.sv
module test_alu8_core;
    logic       clk = 1'b0;
    logic [7:0] opd_a = '0, opd_b = '0, flags_in = '0;
    logic [3:0] op_sel = '0;
    logic [7:0] result, flags_out;
    logic       wr_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [3:0] op;
        logic [7:0] a, b, f;
        logic [7:0] exp_r, exp_f;
        logic       exp_w;
        string      tag;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    alu8_core i_alu8_core (
        .opd_a(opd_a), .opd_b(opd_b), .op_sel(op_sel), .flags_in(flags_in),
        .result(result), .flags_out(flags_out), .wr_en(wr_en)
    );

    function automatic item_t expect_of(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] f);
        item_t it;
        logic [8:0]  s;
        logic [15:0] dbl;
        logic zs, cv;
        logic c, v;
        it.op = op; it.a = a; it.b = b; it.f = f;
        it.exp_r = a; it.exp_f = f; it.exp_w = 1'b1;
        zs = 1'b1; cv = 1'b0; c = f[7]; v = f[4];
        case (op)
            4'd0: begin it.exp_r = b; it.tag = "R10,R4,R9"; end
            4'd1: begin
                s = {1'b0, a} + {1'b0, b};
                it.exp_r = s[7:0]; c = s[8]; cv = 1'b1;
                v = (a[7] == b[7]) && (s[7] != a[7]);
                it.tag = "R1,R4,R9";
            end
            4'd2, 4'd3: begin
                s = {1'b0, a} + {1'b0, ~b} + 9'd1;
                it.exp_r = s[7:0]; c = s[8]; cv = 1'b1;
                v = (a[7] != b[7]) && (s[7] != a[7]);
                it.exp_w = (op == 4'd2);
                it.tag = "R2,R3,R4";
            end
            4'd4, 4'd7: begin it.exp_r = a & b; it.exp_w = (op == 4'd4); it.tag = "R5,R3,R4"; end
            4'd5: begin it.exp_r = a | b; it.tag = "R5,R4"; end
            4'd6: begin it.exp_r = a ^ b; it.tag = "R5,R4"; end
            4'd8: begin
                dbl = {a, a} >> b[2:0];
                it.exp_r = dbl[7:0]; it.tag = "R6,R4";
            end
            4'd9: begin
                it.exp_r = {a[6:0], 1'b0}; c = a[7]; cv = 1'b1;
                v = it.exp_r[7] ^ a[7]; it.tag = "R7";
            end
            4'd10: begin
                it.exp_r = {1'b0, a[7:1]}; c = a[0]; cv = 1'b1;
                v = it.exp_r[7] ^ a[7]; it.tag = "R8";
            end
            default: begin zs = 1'b0; it.exp_w = 1'b0; it.tag = "R11"; end
        endcase
        if (zs) begin
            it.exp_f[6] = (it.exp_r == 8'd0);
            it.exp_f[5] = it.exp_r[7];
        end
        if (cv) begin
            it.exp_f[7] = c;
            it.exp_f[4] = v;
        end
        return it;
    endfunction

    task automatic drive(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input logic [7:0] f);
        @(negedge clk);
        opd_a = a; opd_b = b; op_sel = op; flags_in = f;
        sb.push_back(expect_of(op, a, b, f));
    endtask

    always @(posedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_vec++;
            if (result !== it.exp_r || flags_out !== it.exp_f || wr_en !== it.exp_w) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%h b=%h f=%h: got r=%h f=%h w=%b, expected r=%h f=%h w=%b",
                         it.tag, it.op, it.a, it.b, it.f, result, flags_out, wr_en,
                         it.exp_r, it.exp_f, it.exp_w);
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: signed overflow, unsigned carry to zero
        drive(4'd1, 8'h7F, 8'h01, 8'h00);
        drive(4'd1, 8'hFF, 8'h01, 8'h00);
        drive(4'd1, 8'h80, 8'h80, 8'h08);
        // R2: equal, borrow, signed overflow
        drive(4'd2, 8'h05, 8'h05, 8'h00);
        drive(4'd2, 8'h00, 8'h01, 8'h00);
        drive(4'd2, 8'h80, 8'h01, 8'h00);
        // R3: compare and test drop write-back
        drive(4'd3, 8'h10, 8'h20, 8'h07);
        drive(4'd7, 8'hF0, 8'h0F, 8'h90);
        // R5: logic ops keep C and V
        drive(4'd4, 8'hAA, 8'h55, 8'h90);
        drive(4'd5, 8'h80, 8'h01, 8'h90);
        drive(4'd6, 8'h3C, 8'h3C, 8'h90);
        // R6: rotate amounts, upper amount bits ignored
        drive(4'd8, 8'h81, 8'h01, 8'h00);
        drive(4'd8, 8'h81, 8'h08, 8'h00);
        drive(4'd8, 8'h81, 8'hFB, 8'h90);
        // R7, R8: shifts through carry
        drive(4'd9, 8'h80, 8'h00, 8'h00);
        drive(4'd9, 8'h40, 8'h00, 8'h80);
        drive(4'd10, 8'h01, 8'h00, 8'h00);
        drive(4'd10, 8'h80, 8'h00, 8'h80);
        // R10: pass-through keeps C and V
        drive(4'd0, 8'h12, 8'h00, 8'h9F);
        drive(4'd0, 8'h12, 8'hC3, 8'h00);
        // R11: undefined codes
        drive(4'd11, 8'h5A, 8'hA5, 8'hFF);
        drive(4'd15, 8'h00, 8'h00, 8'h00);
        // R9 and all ops: random sweep
        for (int i = 0; i < 600; i++)
            drive(4'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule